// File: doc/BRIEF.md
# USB device suspend/resume controller

This block watches the decoded line state of a full-speed USB device. After a long idle period it moves the device into suspend. It brings the device back out when the host shows activity on the bus, or when local software requests a remote wakeup. The line state is first passed through a two-stage synchronizer, so the block can be clocked from a free-running or slow clock that is unrelated to the bus.

Two sticky interrupt flags report the suspend transitions. One is set when the device enters suspend and the other when it leaves suspend. Software clears each flag by writing 1 to it. A remote wakeup runs only when the host has granted permission. While it runs, the block asks the transceiver to drive K for a fixed number of cycles, then releases the bus and clears the request bit by itself.

A wake output stays valid while the core clock is stopped. It is built from the exit flag and from the raw line state, so host activity during a clock-gated standby can still wake the system.

Top module: `usb_susp_ctrl`

## Requirements
- R1: While rst_ni is low, suspend_o, entry_flag_o, exit_flag_o, drive_k_o and req_bit_o are all 0. This holds both at start-up and when reset is asserted in the middle of a remote wakeup.
- R2: Line encoding on line_i is 00 = SE0, 01 = J (idle), 10 = K, 11 = SE1. suspend_o rises after the (IDLE_CYCLES+2)th rising clock edge once line_i holds J. Two of those edges are synchronizer stages, and the count starts from a non-idle line.
- R3: Any non-J sample before the count completes restarts the idle count. A run of fewer than IDLE_CYCLES J cycles never causes suspend.
- R4: While suspended, any non-J line state (K, SE0 or SE1) counts as host resume. suspend_o falls after the third rising edge that follows the change.
- R5: entry_flag_o is set in the cycle suspend is entered. exit_flag_o is set in the cycle suspend is left, whether through host resume or remote wakeup. Both flags stay set until they are cleared.
- R6: A one-cycle pulse on entry_clr_i or exit_clr_i clears the matching flag at the next edge. If a clear and a new event fall in the same cycle, the flag stays set.
- R7: A wake_req_i pulse is accepted when the device is suspended and rwu_en_i is 1. At the next edge suspend_o drops and req_bit_o and drive_k_o rise. drive_k_o then stays high for exactly K_CYCLES cycles, after which drive_k_o and req_bit_o both return to 0.
- R8: A wake_req_i pulse has no effect when the device is not suspended or when rwu_en_i is 0. In that case req_bit_o and drive_k_o stay 0 and suspend_o keeps its value.
- R9: If host resume reaches the synchronized line in the same cycle that a wake request arrives, host resume wins. Suspend is left, exit_flag_o is set, and no K is driven.
- R10: wake_o is 1 whenever exit_flag_o is 1. It is also 1 while suspended and line_i is not J. In the second case it follows line_i combinationally, even with the clock stopped.
- R11: During the K drive the line state is ignored and the idle count is held at zero. After the release, suspend is entered on the IDLE_CYCLES-th edge of continuous J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (may be gated in standby) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Decoded bus line state, asynchronous |
| rwu_en_i | input | 1 | Remote wakeup permitted by host |
| wake_req_i | input | 1 | Write-1 strobe to the resume-request bit |
| entry_clr_i | input | 1 | Write-1-to-clear strobe for the entry flag |
| exit_clr_i | input | 1 | Write-1-to-clear strobe for the exit flag |
| suspend_o | output | 1 | Device is suspended |
| entry_flag_o | output | 1 | Sticky suspend-entry interrupt flag |
| exit_flag_o | output | 1 | Sticky suspend-exit interrupt flag |
| drive_k_o | output | 1 | Request to the transceiver to drive K |
| req_bit_o | output | 1 | Read-back of the resume-request bit |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
Two events can land in one cycle: host resume activity reaching the synchronized line, and a software wakeup request. The bench sets the line to K and counts two edges for the synchronizer. It then pulses the request in the cycle whose closing edge makes the device leave suspend. It judges the result by exit_flag_o being set while drive_k_o and req_bit_o stay low. A second collision is also provoked: the entry-flag clear is held in the exact cycle of suspend entry, and the bench expects the flag to remain set.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_SUSP   = 2'b01,
    ST_WAKE   = 2'b10
  } state_e;
endpackage

// File: rtl/usb_susp_sync.sv
module usb_susp_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/usb_susp_counter.sv
module usb_susp_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (hit_o)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R3
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/usb_susp_flag.sv
module usb_susp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);

  // R6
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int IDLE_CYCLES = 144000,  // 3 ms at 48 MHz
  parameter int K_CYCLES    = 480000   // 10 ms at 48 MHz
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       rwu_en_i,
  input  logic       wake_req_i,
  input  logic       entry_clr_i,
  input  logic       exit_clr_i,
  output logic       suspend_o,
  output logic       entry_flag_o,
  output logic       exit_flag_o,
  output logic       drive_k_o,
  output logic       req_bit_o,
  output logic       wake_o
);
  logic [1:0] line_s;
  logic       line_idle;
  state_e     state_q, state_d;
  logic       idle_hit, k_hit;
  logic       host_res, accept;
  logic       entry_set, exit_set;
  logic       req_q;

  usb_susp_sync #(.W(2), .RST_VAL(LS_SE0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign line_idle = (line_s == LS_J);

  usb_susp_counter #(.LIMIT(IDLE_CYCLES)) u_idle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!((state_q == ST_ACTIVE) && line_idle)),
    .inc_i ((state_q == ST_ACTIVE) && line_idle),
    .hit_o (idle_hit)
  );

  usb_susp_counter #(.LIMIT(K_CYCLES)) u_k_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_WAKE),
    .inc_i (state_q == ST_WAKE),
    .hit_o (k_hit)
  );

  // host activity has priority over a same-cycle wake request
  assign host_res = (state_q == ST_SUSP) && !line_idle;
  assign accept   = (state_q == ST_SUSP) && line_idle && wake_req_i && rwu_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (idle_hit) state_d = ST_SUSP;
      ST_SUSP: begin
        if (host_res)    state_d = ST_ACTIVE;
        else if (accept) state_d = ST_WAKE;
      end
      ST_WAKE:   if (k_hit) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= 1'b0;
    else if (accept) req_q <= 1'b1;
    else if (k_hit)  req_q <= 1'b0;
  end

  assign entry_set = (state_q == ST_ACTIVE) && idle_hit;
  assign exit_set  = host_res || accept;

  usb_susp_flag u_entry_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (entry_set),
    .clr_i (entry_clr_i),
    .q_o   (entry_flag_o)
  );

  usb_susp_flag u_exit_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (exit_set),
    .clr_i (exit_clr_i),
    .q_o   (exit_flag_o)
  );

  assign suspend_o = (state_q == ST_SUSP);
  assign drive_k_o = (state_q == ST_WAKE);
  assign req_bit_o = req_q;
  // unclocked path from raw line: valid with clk_i stopped
  assign wake_o    = exit_flag_o || (suspend_o && (line_i != LS_J));

  // R5
  entry_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspend_o) |-> entry_flag_o);

  // R5
  exit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(suspend_o) |-> exit_flag_o);

  // R7
  drive_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_k_o |-> (req_bit_o && !suspend_o));

  // R8
  ignored_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_req_i && !(suspend_o && rwu_en_i)) |=> !$rose(drive_k_o));

  // R9
  resume_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_o && (line_s != LS_J) && wake_req_i) |=> (!drive_k_o && !suspend_o));

  // R11
  release_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_k_o) |-> (!suspend_o && !req_bit_o));

  // R10
  wake_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_flag_o |-> wake_o);
endmodule

// File: tb/usb_susp_ctrl_test.sv
module usb_susp_ctrl_test;
  import usb_susp_pkg::*;

  localparam int IDLE = 40;
  localparam int KD   = 25;

  logic       clk = 1'b0;
  logic       clk_en = 1'b1;
  logic       gclk;
  logic       rst_ni = 1'b0;
  logic [1:0] line = LS_SE0;
  logic       rwu_en = 1'b0, wake_req = 1'b0, entry_clr = 1'b0, exit_clr = 1'b0;
  logic       suspend, entry_flag, exit_flag, drive_k, req_bit, wake;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;
  assign gclk = clk & clk_en;

  usb_susp_ctrl #(.IDLE_CYCLES(IDLE), .K_CYCLES(KD)) uut (
    .clk_i       (gclk),
    .rst_ni      (rst_ni),
    .line_i      (line),
    .rwu_en_i    (rwu_en),
    .wake_req_i  (wake_req),
    .entry_clr_i (entry_clr),
    .exit_clr_i  (exit_clr),
    .suspend_o   (suspend),
    .entry_flag_o(entry_flag),
    .exit_flag_o (exit_flag),
    .drive_k_o   (drive_k),
    .req_bit_o   (req_bit),
    .wake_o      (wake)
  );

  // edges from a line change to the suspend output
  function automatic int entry_edges(input int idle);
    return idle + 2;
  endfunction

  function automatic logic [1:0] non_idle(input int unsigned sel);
    case (sel)
      0:       return LS_SE0;
      1:       return LS_K;
      default: return LS_SE1;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 suspend in reset", suspend, 0);
    chk("R1 entry flag in reset", entry_flag, 0);
    chk("R1 exit flag in reset", exit_flag, 0);
    chk("R1 drive in reset", drive_k, 0);
    chk("R1 req in reset", req_bit, 0);
    rst_ni = 1'b1;
    tick(2);

    // R3 / R8 random short idle runs with random requests while active
    for (int it = 0; it < 30; it++) begin
      int unsigned jl = $urandom_range(IDLE - 1, 0);
      int unsigned nl = $urandom_range(4, 1);
      line = LS_J;
      if (jl > 0) tick(int'(jl));
      chk("R3 no suspend on short idle", suspend, 0);
      line = non_idle($urandom_range(2, 0));
      rwu_en = 1'($urandom_range(1, 0));
      wake_req = 1'b1;
      tick(1);
      wake_req = 1'b0;
      if (nl > 1) tick(int'(nl) - 1);
      chk("R8 drive ignored while active", drive_k, 0);
      chk("R8 req ignored while active", req_bit, 0);
    end
    chk("R3 no entry flag", entry_flag, 0);

    // R2 exact entry timing, with R6 clear colliding with the entry
    line = LS_J;
    tick(entry_edges(IDLE) - 1);
    chk("R2 not yet suspended", suspend, 0);
    entry_clr = 1'b1;
    tick(1);
    entry_clr = 1'b0;
    chk("R2 suspended", suspend, 1);
    chk("R6 set wins over clear", entry_flag, 1);
    tick(5);
    chk("R5 entry flag sticky", entry_flag, 1);

    // R8 request ignored with permission clear
    rwu_en = 1'b0;
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    chk("R8 no drive without permission", drive_k, 0);
    chk("R8 no req without permission", req_bit, 0);
    chk("R8 still suspended", suspend, 1);

    // R6 clear entry flag
    entry_clr = 1'b1;
    tick(1);
    entry_clr = 1'b0;
    chk("R6 entry flag cleared", entry_flag, 0);
    chk("R10 no wake on idle suspend", wake, 0);

    // R10 host resume seen with the clock stopped
    clk_en = 1'b0;
    #20;
    line = LS_K;
    #20;
    chk("R10 wake with clock stopped", wake, 1);
    chk("R10 state frozen", suspend, 1);
    clk_en = 1'b1;
    tick(2);
    chk("R4 still suspended after sync", suspend, 1);
    tick(1);
    chk("R4 left suspend on K", suspend, 0);
    chk("R5 exit flag set by host resume", exit_flag, 1);
    chk("R10 wake held by exit flag", wake, 1);
    exit_clr = 1'b1;
    tick(1);
    exit_clr = 1'b0;
    chk("R6 exit flag cleared", exit_flag, 0);
    chk("R10 no wake when active", wake, 0);

    // R4 SE0 also resumes
    line = LS_J;
    tick(entry_edges(IDLE));
    chk("R2 suspended again", suspend, 1);
    line = LS_SE0;
    tick(3);
    chk("R4 left suspend on SE0", suspend, 0);
    exit_clr = 1'b1;
    tick(1);
    exit_clr = 1'b0;

    // R7 remote wakeup
    line = LS_J;
    tick(entry_edges(IDLE));
    chk("R2 suspended before wakeup", suspend, 1);
    rwu_en = 1'b1;
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    chk("R7 drive starts", drive_k, 1);
    chk("R7 req set", req_bit, 1);
    chk("R7 suspend left", suspend, 0);
    chk("R5 exit flag on wakeup", exit_flag, 1);
    tick(KD - 1);
    chk("R7 drive held", drive_k, 1);
    chk("R7 req held", req_bit, 1);
    tick(1);
    chk("R7 drive released", drive_k, 0);
    chk("R7 req auto-cleared", req_bit, 0);
    // R11 idle counted afresh from release
    tick(IDLE - 1);
    chk("R11 not suspended early", suspend, 0);
    tick(1);
    chk("R11 suspended after fresh idle", suspend, 1);

    // R9 host resume and wake request in one cycle
    exit_clr = 1'b1;
    tick(1);
    exit_clr = 1'b0;
    line = LS_K;
    tick(2);
    chk("R9 suspended before collision", suspend, 1);
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    chk("R9 left suspend", suspend, 0);
    chk("R9 no drive", drive_k, 0);
    chk("R9 no req", req_bit, 0);
    chk("R9 exit flag", exit_flag, 1);
    tick(3);
    chk("R9 still no drive", drive_k, 0);

    // R1 reset in the middle of a wakeup
    line = LS_J;
    tick(entry_edges(IDLE));
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    tick(5);
    chk("R7 driving before reset", drive_k, 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 drive released by reset", drive_k, 0);
    chk("R1 req cleared by reset", req_bit, 0);
    chk("R1 flags cleared by reset", {entry_flag, exit_flag}, 0);
    chk("R1 suspend cleared by reset", suspend, 0);
    tick(1);
    rst_ni = 1'b1;
    tick(2);

    finish_run();
  end
endmodule